// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host end of a two-wire debug link. Each request carries one register access to a debug port (DP) or access port (AP). For that access the engine generates the serial clock, sends the 8-bit request header, and releases the data line for turnaround. It then collects the target's 3-bit acknowledge and moves a 32-bit word with its parity bit in the direction the request asks for. Last, it clocks out the number of idle cycles given with the request. The data line is bidirectional, so it appears as three signals: output value, output enable and input.

The issuing logic presents a request while `busy` is low. One cycle later `busy` goes high and the line activity begins. A one-cycle `rsp_valid` pulse returns the 2-bit status and, for reads, the captured word. A write to the DP target-select register (DP, write, address bits `2'b11`) gets no acknowledge from the target. The engine ignores the line during those three bits and completes the write normally. The serial clock runs from the system clock through a divider that the caller sets.

Top module: `swd_host_engine`

## Requirements
- R1: The header goes out least significant bit first, one bit per serial-clock period, with the host driving: bit0 = 1, bit1 = `req_ap`, bit2 = `req_rnw`, bit3 = `req_addr[0]`, bit4 = `req_addr[1]`, bit5 = parity, bit6 = 0, bit7 = 1.
- R2: The header parity bit is 1 exactly when an odd number of `req_ap`, `req_rnw`, `req_addr[1:0]` are 1.
- R3: After the header, the host releases the line (`swdio_oe` low) for one turnaround period. It then samples three acknowledge bits, first received is bit0, at serial-clock rising edges with the line still released. OK is `3'b001`, WAIT is `3'b010`, FAULT is `3'b100`.
- R4: For a write acknowledged OK, one more released turnaround period follows. The host then drives 32 data bits, least significant first, and then an even-parity bit equal to the XOR of the 32 data bits.
- R5: For a read acknowledged OK, the line stays released for 33 periods, in which the host samples 32 data bits (least significant first) and a parity bit, and then for one turnaround period. `rsp_rdata` returns the captured word.
- R6: A data parity mismatch on a read gives status PROTO while `rsp_rdata` still returns the captured word. Status codes: OK = 0, WAIT = 1, FAULT = 2, PROTO = 3.
- R7: An acknowledge of WAIT or FAULT gives status WAIT or FAULT. Any other value gives PROTO. In all three cases the data phase and idle cycles are skipped and the transfer ends after one released turnaround period, 13 periods in all.
- R8: For a DP write to address `2'b11`, the acknowledge is ignored and the write completes with status OK. An AP write or a DP read to that address gets no such exemption.
- R9: After a completed data phase, the host drives the line low for `req_idle` serial-clock periods before responding.
- R10: Each serial-clock phase lasts `clk_half`+1 system cycles. The serial clock is low while idle. `swdio_out` changes only after a falling edge. `rsp_valid` is a single-cycle pulse, high after the system edge that performs the final falling edge.
- R11: During and after reset: `busy`, `rsp_valid` and `swclk` are 0, `swdio_oe` is 1 and `swdio_out` is 0, even when reset cuts a transfer short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_half | input | DIV_W | Serial-clock phase length minus one, in system cycles |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_ap | input | 1 | 1 selects an access port, 0 the debug port |
| req_rnw | input | 1 | 1 for read, 0 for write |
| req_addr | input | 2 | Register address bits 3:2 |
| req_wdata | input | 32 | Write value |
| req_idle | input | IDLE_W | Idle periods appended after the data phase |
| busy | output | 1 | Transfer in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 0 OK, 1 WAIT, 2 FAULT, 3 PROTO |
| rsp_rdata | output | 32 | Captured read word |
| swclk | output | 1 | Serial clock to the target |
| swdio_out | output | 1 | Line value driven by the host |
| swdio_oe | output | 1 | 1 while the host drives the line |
| swdio_in | input | 1 | Line value seen from the target |

## Verification
Every result falls due a fixed number of system cycles after the request is taken. The count is N·2·(`clk_half`+1), where N is 46 plus the idle count for a transfer that gets a data phase and 13 for one that does not. The bench computes N from the vector alone and checks that `rsp_valid` shows up on exactly that cycle. Line values are captured on each serial-clock rising edge and stored by period index. Each protocol field is then checked at the period where the requirements place it. The target model changes its reply only after falling edges, so every sample the engine takes at a rising edge is stable.

// File: rtl/swd_pkg.sv
package swd_pkg;

  typedef enum logic [1:0] {
    ST_OK    = 2'b00,
    ST_WAIT  = 2'b01,
    ST_FAULT = 2'b10,
    ST_PROTO = 2'b11
  } swd_status_e;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  // Request header, bit0 is sent first.
  function automatic logic [7:0] swd_header(input logic ap, input logic rnw,
                                            input logic [1:0] addr);
    logic par;
    par = ap ^ rnw ^ addr[0] ^ addr[1];
    return {1'b1, 1'b0, par, addr, rnw, ap, 1'b1};
  endfunction

  // Data word with its even-parity bit on top.
  function automatic logic [32:0] swd_data_frame(input logic [31:0] d);
    return {^d, d};
  endfunction

  // The one request whose acknowledge the target never sends.
  function automatic logic swd_no_ack(input logic ap, input logic rnw,
                                      input logic [1:0] addr);
    return !ap && !rnw && (addr == 2'b11);
  endfunction

  function automatic swd_status_e swd_ack_status(input logic [2:0] ack);
    case (ack)
      ACK_OK:    return ST_OK;
      ACK_WAIT:  return ST_WAIT;
      ACK_FAULT: return ST_FAULT;
      default:   return ST_PROTO;
    endcase
  endfunction

endpackage

// File: rtl/swd_clkgen.sv
module swd_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             swclk,
  output logic             rise_evt,
  output logic             fall_evt
);

  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick     = run && (cnt == half);
  assign rise_evt = tick && !swclk;
  assign fall_evt = tick && swclk;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt   <= '0;
      swclk <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      swclk <= ~swclk;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  AST_CLK_LOW_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run)) |-> !swclk); // R10
  AST_CLK_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (swclk != $past(swclk)) |-> $past(run)); // R10

endmodule

// File: rtl/swd_xfer_fsm.sv
module swd_xfer_fsm
  import swd_pkg::*;
#(
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_ap,
  input  logic              req_rnw,
  input  logic [1:0]        req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [IDLE_W-1:0] req_idle,
  input  logic              rise_evt,
  input  logic              fall_evt,
  output logic              run,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [31:0]       rsp_rdata,
  output logic              swdio_out,
  output logic              swdio_oe,
  input  logic              swdio_in
);

  localparam int CNT_W = (IDLE_W > 6) ? IDLE_W : 6;

  typedef enum logic [3:0] {
    P_IDLE, P_HDR, P_TRN1, P_ACK, P_TRNW, P_WDATA, P_RDATA, P_TRNR, P_TRNE, P_PAD
  } phase_e;

  phase_e            phase;
  logic [CNT_W-1:0]  bitcnt;
  logic [7:0]        hdr_q;
  logic [32:0]       wd_q;
  logic [32:0]       rd_sr;
  logic [2:0]        ack_sr;
  logic              rnw_q, skip_q;
  logic [IDLE_W-1:0] idle_q;
  swd_status_e       status_q, end_status;

  // Named events for the assertions and the sequencing below.
  logic accept, ack_sample, rd_sample, ack_pass, par_bad;
  logic data_end, last_pad, do_finish, do_pad;

  assign accept     = req_valid && (phase == P_IDLE);
  assign ack_sample = rise_evt && (phase == P_ACK);
  assign rd_sample  = rise_evt && (phase == P_RDATA);
  assign ack_pass   = skip_q || (ack_sr == ACK_OK);
  assign par_bad    = rd_sr[32] != (^rd_sr[31:0]);
  assign last_pad   = bitcnt == (CNT_W'(idle_q) - CNT_W'(1));
  assign data_end   = fall_evt && (((phase == P_WDATA) && (bitcnt == CNT_W'(32)))
                                   || (phase == P_TRNR));
  assign do_pad     = data_end && (idle_q != '0);
  assign do_finish  = (data_end && (idle_q == '0))
                   || (fall_evt && (phase == P_TRNE))
                   || (fall_evt && (phase == P_PAD) && last_pad);
  assign end_status = ((phase == P_TRNR) && par_bad) ? ST_PROTO : status_q;

  assign run      = (phase != P_IDLE);
  assign swdio_oe = (phase == P_IDLE) || (phase == P_HDR) || (phase == P_WDATA)
                 || (phase == P_PAD);

  always_comb begin
    case (phase)
      P_HDR:   swdio_out = hdr_q[bitcnt[2:0]];
      P_WDATA: swdio_out = wd_q[bitcnt[5:0]];
      default: swdio_out = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= P_IDLE;
      bitcnt     <= '0;
      hdr_q      <= '0;
      wd_q       <= '0;
      rd_sr      <= '0;
      ack_sr     <= '0;
      rnw_q      <= 1'b0;
      skip_q     <= 1'b0;
      idle_q     <= '0;
      status_q   <= ST_OK;
      rsp_valid  <= 1'b0;
      rsp_status <= 2'b00;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (ack_sample) ack_sr <= {swdio_in, ack_sr[2:1]};
      if (rd_sample)  rd_sr  <= {swdio_in, rd_sr[32:1]};
      if (accept) begin
        phase    <= P_HDR;
        bitcnt   <= '0;
        hdr_q    <= swd_header(req_ap, req_rnw, req_addr);
        wd_q     <= swd_data_frame(req_wdata);
        rnw_q    <= req_rnw;
        skip_q   <= swd_no_ack(req_ap, req_rnw, req_addr);
        idle_q   <= req_idle;
        status_q <= ST_OK;
      end else if (do_finish) begin
        phase      <= P_IDLE;
        rsp_valid  <= 1'b1;
        rsp_status <= end_status;
        if (rnw_q) rsp_rdata <= rd_sr[31:0];
      end else if (do_pad) begin
        phase    <= P_PAD;
        bitcnt   <= '0;
        status_q <= end_status;
      end else if (fall_evt) begin
        bitcnt <= bitcnt + 1'b1;
        case (phase)
          P_HDR:   if (bitcnt == CNT_W'(7)) begin phase <= P_TRN1; bitcnt <= '0; end
          P_TRN1:  begin phase <= P_ACK; bitcnt <= '0; end
          P_ACK:   if (bitcnt == CNT_W'(2)) begin
                     bitcnt <= '0;
                     if (ack_pass) phase <= rnw_q ? P_RDATA : P_TRNW;
                     else begin
                       phase    <= P_TRNE;
                       status_q <= swd_ack_status(ack_sr);
                     end
                   end
          P_TRNW:  begin phase <= P_WDATA; bitcnt <= '0; end
          P_RDATA: if (bitcnt == CNT_W'(32)) begin phase <= P_TRNR; bitcnt <= '0; end
          default: ;
        endcase
      end
    end
  end

  AST_OUT_ONLY_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(fall_evt)) |-> $stable(swdio_out)); // R10
  AST_ACK_LINE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    ack_sample |-> !swdio_oe); // R3
  AST_DATA_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == P_RDATA || phase == P_TRNW) && $past(phase) == P_ACK)
      |-> (skip_q || ack_sr == ACK_OK)); // R7
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_PAD_DRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_PAD) |-> (swdio_oe && !swdio_out)); // R9
  AST_NO_ACK_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && skip_q) |-> (rsp_status == ST_OK)); // R8

endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine #(
  parameter int DIV_W  = 8,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_half,
  input  logic              req_valid,
  input  logic              req_ap,
  input  logic              req_rnw,
  input  logic [1:0]        req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [IDLE_W-1:0] req_idle,
  output logic              busy,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [31:0]       rsp_rdata,
  output logic              swclk,
  output logic              swdio_out,
  output logic              swdio_oe,
  input  logic              swdio_in
);

  logic run, rise_evt, fall_evt;

  assign busy = run;

  swd_clkgen #(.DIV_W(DIV_W)) i_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .half     (clk_half),
    .swclk    (swclk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  swd_xfer_fsm #(.IDLE_W(IDLE_W)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ap     (req_ap),
    .req_rnw    (req_rnw),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_idle   (req_idle),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt),
    .run        (run),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .rsp_rdata  (rsp_rdata),
    .swdio_out  (swdio_out),
    .swdio_oe   (swdio_oe),
    .swdio_in   (swdio_in)
  );

endmodule

// File: tb/test_swd_host_engine.sv
module test_swd_host_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  clk_half = '0;
  logic        req_valid = 1'b0, req_ap = 1'b0, req_rnw = 1'b0;
  logic [1:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  req_idle = '0;
  logic        busy, rsp_valid, swclk, swdio_out, swdio_oe, swdio_in;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_rdata;

  swd_host_engine i_swd_host_engine (
    .clk(clk), .rst_n(rst_n), .clk_half(clk_half), .req_valid(req_valid),
    .req_ap(req_ap), .req_rnw(req_rnw), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_idle(req_idle), .busy(busy), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_rdata(rsp_rdata), .swclk(swclk), .swdio_out(swdio_out), .swdio_oe(swdio_oe),
    .swdio_in(swdio_in)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Target model: reply bits indexed by serial-clock period.
  int          nfall = 0, base = 0;
  logic [2:0]  t_ack = 3'b111;
  logic [31:0] t_rd = '0;
  logic        t_pflip = 1'b0, t_rnw = 1'b0;
  bit          cap_d [0:127];
  bit          cap_o [0:127];

  function automatic logic tgt_bit(input int s, input logic [2:0] ack,
                                   input logic rnw, input logic [31:0] rd,
                                   input logic pflip);
    if (s >= 9 && s <= 11) return ack[s-9];
    if (rnw && s >= 12 && s <= 43) return rd[s-12];
    if (rnw && s == 44) return (^rd) ^ pflip;
    return 1'b1;
  endfunction

  assign swdio_in = tgt_bit(nfall - base, t_ack, t_rnw, t_rd, t_pflip);

  always @(negedge swclk) nfall <= nfall + 1;
  always @(posedge swclk) begin
    if (nfall - base >= 0 && nfall - base < 128) begin
      cap_d[nfall - base] = swdio_out;
      cap_o[nfall - base] = swdio_oe;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        ap;
    logic        rnw;
    logic [1:0]  addr;
    logic [31:0] wd;
    logic [3:0]  idle;
    logic [2:0]  ack;
    logic [31:0] rd;
    logic        pflip;
    logic [1:0]  half;
    logic [1:0]  exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 2'd0, 32'h0,        4'd0, 3'b001, 32'h2BA01477, 1'b0, 2'd0, 2'd0},
    '{1'b1, 1'b0, 2'd1, 32'hDEADBEEF, 4'd3, 3'b001, 32'h0,        1'b0, 2'd1, 2'd0},
    '{1'b1, 1'b1, 2'd3, 32'h0,        4'd2, 3'b001, 32'h80000001, 1'b0, 2'd2, 2'd0},
    '{1'b0, 1'b0, 2'd2, 32'h12345678, 4'd2, 3'b010, 32'h0,        1'b0, 2'd0, 2'd1},
    '{1'b1, 1'b1, 2'd1, 32'h0,        4'd1, 3'b100, 32'h0,        1'b0, 2'd1, 2'd2},
    '{1'b0, 1'b1, 2'd0, 32'h0,        4'd0, 3'b111, 32'h0,        1'b0, 2'd0, 2'd3},
    '{1'b1, 1'b1, 2'd2, 32'h0,        4'd1, 3'b001, 32'h0F0F00FF, 1'b1, 2'd0, 2'd3},
    '{1'b0, 1'b0, 2'd3, 32'h01002927, 4'd1, 3'b111, 32'h0,        1'b0, 2'd0, 2'd0},
    '{1'b1, 1'b0, 2'd3, 32'h55AA55AA, 4'd0, 3'b111, 32'h0,        1'b0, 2'd0, 2'd3},
    '{1'b0, 1'b1, 2'd3, 32'h0,        4'd0, 3'b111, 32'h0,        1'b0, 2'd0, 2'd3},
    '{1'b0, 1'b0, 2'd0, 32'hFFFFFFFE, 4'd0, 3'b001, 32'h0,        1'b0, 2'd3, 2'd0}
  };

  task automatic run_vec(input int k, input vec_t v);
    bit   pass, hdr_ok, ok;
    int   nslot, m, c0, guard;
    logic [7:0] hexp, hgot;
    pass  = (v.ack == 3'b001) || (!v.ap && !v.rnw && v.addr == 2'd3);
    nslot = pass ? 46 + int'(v.idle) : 13;
    m     = nslot * 2 * (int'(v.half) + 1);
    t_ack = v.ack; t_rnw = v.rnw; t_rd = v.rd; t_pflip = v.pflip;
    base  = nfall;
    req_ap = v.ap; req_rnw = v.rnw; req_addr = v.addr; req_wdata = v.wd;
    req_idle = {4'b0, v.idle}; clk_half = {6'b0, v.half}; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    c0 = cyc;
    guard = 0;
    while (!rsp_valid && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    // R10: response due N*2*(half+1) cycles after the accepting edge
    chk(cyc - c0 == m, $sformatf("R10 v%0d latency", k), 64'(cyc - c0), 64'(m));
    chk(rsp_status == v.exp, $sformatf("R7 v%0d status", k), 64'(rsp_status), 64'(v.exp));
    // R1 R2: header bits and parity
    hexp = {1'b1, 1'b0, v.ap ^ v.rnw ^ v.addr[0] ^ v.addr[1], v.addr, v.rnw, v.ap, 1'b1};
    hdr_ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hgot[i] = cap_d[i];
      if (!cap_o[i]) hdr_ok = 1'b0;
    end
    chk(hdr_ok && hgot == hexp, $sformatf("R1 R2 v%0d header", k), 64'(hgot), 64'(hexp));
    // R3: turnaround and acknowledge periods released
    ok = !cap_o[8] && !cap_o[9] && !cap_o[10] && !cap_o[11];
    chk(ok, $sformatf("R3 v%0d release", k), 64'(ok), 64'd1);
    if (!pass) begin
      chk(!cap_o[12], $sformatf("R7 v%0d final turnaround", k), 64'(cap_o[12]), 64'd0);
    end else if (!v.rnw) begin
      logic [32:0] wgot;
      ok = !cap_o[12];
      for (int i = 0; i < 33; i++) begin
        wgot[i] = cap_d[13+i];
        if (!cap_o[13+i]) ok = 1'b0;
      end
      chk(ok && wgot == {^v.wd, v.wd}, $sformatf("R4 R8 v%0d write data", k),
          64'(wgot), 64'({^v.wd, v.wd}));
    end else begin
      ok = 1'b1;
      for (int i = 12; i < 46; i++) if (cap_o[i]) ok = 1'b0;
      chk(ok, $sformatf("R5 v%0d read released", k), 64'(ok), 64'd1);
      chk(rsp_rdata == v.rd, $sformatf("R5 R6 v%0d rdata", k), 64'(rsp_rdata), 64'(v.rd));
    end
    if (pass && v.idle != 0) begin
      ok = 1'b1;
      for (int i = 46; i < 46 + int'(v.idle); i++) if (!cap_o[i] || cap_d[i]) ok = 1'b0;
      chk(ok, $sformatf("R9 v%0d idle low", k), 64'(ok), 64'd1);
    end
    @(negedge clk);
    chk(!rsp_valid && !busy && !swclk, $sformatf("R10 v%0d back to idle", k),
        64'({rsp_valid, busy, swclk}), 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(!busy && !rsp_valid && !swclk && swdio_oe && !swdio_out, "R11 reset state",
        64'({busy, rsp_valid, swclk, swdio_oe, swdio_out}), 64'b00010);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NV; k++) run_vec(k, VECS[k]);
    // R11: reset cutting a read short
    base = nfall; t_ack = 3'b001; t_rnw = 1'b1; t_rd = 32'hCAFEF00D; t_pflip = 1'b0;
    req_ap = 1'b1; req_rnw = 1'b1; req_addr = 2'd0; req_idle = 8'd0; clk_half = 8'd1;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (60) @(negedge clk);
    chk(busy, "R11 busy mid transfer", 64'(busy), 64'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !rsp_valid && !swclk && swdio_oe && !swdio_out, "R11 reset mid transfer",
        64'({busy, rsp_valid, swclk, swdio_oe, swdio_out}), 64'b00010);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(!busy && !swclk, "R11 stays idle after reset", 64'({busy, swclk}), 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_500_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule